// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits behind a frame assembly stage in a CAN receiver. Once a frame has been fully decoded, the assembly stage raises a single-cycle strobe. With it come the identifier, the extended-format flag, the remote-request flag and the first two data bytes. The block compares the frame against six filters arranged in two groups. Each group has its own mask. The block then decides whether the frame is kept and which of two receive buffers takes it. Filters 0 and 1 with mask 0 serve buffer 0, and filters 2 to 5 with mask 1 serve buffer 1. When both groups match, buffer 0 wins.

Each buffer has an occupancy flag. A load sets the flag, and a one-cycle release pulse from the host clears it. A frame aimed at an occupied buffer is dropped and reported as an overflow. The exception is rollover: when it is enabled, a frame that buffer 0 cannot take goes to buffer 1. For standard data frames, the low sixteen filter and mask bits compare against the two data bytes, so a node can select traffic by payload prefix.

Filters, masks, the two buffer modes and the rollover enable are loaded through a small write port. That port accepts writes only while configuration mode is held, and frames are not processed during that time.

Top module: `can_rx_accept`

## Requirements
- R1: After reset no load or overflow pulse is present, both occupancy flags are clear, every mask and filter is zero with its extended flag clear, both modes are 00 and rollover is off. With these defaults, any standard frame goes to buffer 0 with filter index 0, and no extended frame is accepted.
- R2: A filter matches when two conditions hold. First, for every position where its group mask bit is 1, the frame bit equals the filter bit; positions where the mask bit is 0 are ignored. Second, the filter's extended flag (write data bit 29) equals the frame's IDE flag.
- R3: Filters 0–1 use mask 0 and feed buffer 0, and filters 2–5 use mask 1 and feed buffer 1. A frame that both groups accept goes to buffer 0.
- R4: `hit_idx` reports the lowest-numbered matching filter in the group that accepted the frame. It reads 7 when the buffer accepted the frame under mode 11. It updates only when a load occurs.
- R5: Each buffer mode works as follows. 00 accepts standard or extended frames that pass the filters. 01 accepts only standard frames that pass. 10 accepts only extended frames that pass. 11 accepts every frame and ignores the filters.
- R6: The identifier layout is bits 28:18 for the 11-bit base identifier and bits 17:0 for the extension, used for frames, masks and filters alike. For a standard data frame, bits 17:16 are ignored, bits 15:8 compare with data byte 0 and bits 7:0 compare with data byte 1. For a standard remote frame, bits 17:0 are ignored.
- R7: A load pulse appears for one cycle on the clock edge that samples the frame strobe, and the buffer's occupancy flag goes high on that same edge. A release pulse clears the flag one edge later.
- R8: A frame aimed at an occupied buffer is discarded when rollover does not apply. In that case `ovf` pulses for one cycle, no load happens, and the occupancy flags are unchanged.
- R9: When rollover is enabled (control bit 4) and buffer 0 is occupied, a frame accepted by group 0 is loaded into buffer 1 with group 0's filter index. If buffer 1 is occupied as well, the frame overflows.
- R10: The write address map is as follows. Addresses 0–5 hold filters, with the value in bits 28:0 and the extended flag in bit 29. Addresses 6 and 7 hold masks 0 and 1. Address 8 is control, with mode 0 in bits 1:0, mode 1 in bits 3:2 and rollover in bit 4. Writes made while `cfg_mode` is low are ignored.
- R11: Frame strobes that arrive while `cfg_mode` is high produce no load and no overflow.
- R12: At most one buffer is loaded per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode: unlocks writes and halts reception |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 30 | Write data |
| frm_valid | input | 1 | One-cycle strobe for an assembled frame |
| frm_ide | input | 1 | Frame uses the extended identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Frame identifier, base in bits 28:18 |
| frm_db0 | input | 8 | First data byte |
| frm_db1 | input | 8 | Second data byte |
| rel0 | input | 1 | Host release of buffer 0 |
| rel1 | input | 1 | Host release of buffer 1 |
| load0 | output | 1 | Copy the frame into buffer 0 |
| load1 | output | 1 | Copy the frame into buffer 1 |
| hit_idx | output | 3 | Filter that caused the last load, 7 for accept-all |
| ovf | output | 1 | Frame discarded because its buffer was occupied |
| full0 | output | 1 | Buffer 0 occupied |
| full1 | output | 1 | Buffer 1 occupied |

## Verification
The assertions rely on a few properties of the inputs. Frame strobes last one cycle, and the frame fields are stable while a strobe is high. A release pulse never lands on the same edge as a load of that buffer. `cfg_mode` changes only between frames. The directed stimulus respects all of this. Each frame is driven for exactly one cycle between falling edges, releases are issued as separate steps after the result has been sampled, and configuration writes happen in dedicated phases where no frame is in flight.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int CAN_ID_W  = 29;
  localparam int CAN_SID_W = 11;
  localparam int CAN_DB_W  = 8;
  localparam int CAN_NFILT = 6;
  localparam int CAN_NF0   = 2;

  typedef enum logic [1:0] {
    RXM_BOTH = 2'b00,
    RXM_STD  = 2'b01,
    RXM_EXT  = 2'b10,
    RXM_ANY  = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/can_acc_cfg.sv
module can_acc_cfg
  import can_acc_pkg::*;
#(
  parameter int ID_W  = CAN_ID_W,
  parameter int NFILT = CAN_NFILT,
  parameter int AW    = 4,
  parameter int DW    = ID_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_mode,
  input  logic                        cfg_we,
  input  logic [AW-1:0]               cfg_addr,
  input  logic [DW-1:0]               cfg_wdata,
  output logic [NFILT-1:0][ID_W-1:0]  filt,
  output logic [NFILT-1:0]            fext,
  output logic [1:0][ID_W-1:0]        mask,
  output rx_mode_e                    mode0,
  output rx_mode_e                    mode1,
  output logic                        roll
);
  localparam int MASK_BASE = NFILT;
  localparam int CTRL_ADDR = NFILT + 2;

  logic [NFILT-1:0][ID_W-1:0] filt_q, filt_d;
  logic [NFILT-1:0]           fext_q, fext_d;
  logic [1:0][ID_W-1:0]       mask_q, mask_d;
  rx_mode_e                   mode0_q, mode0_d, mode1_q, mode1_d;
  logic                       roll_q, roll_d;
  logic                       wr_en;

  assign wr_en = cfg_we && cfg_mode;

  always_comb begin
    filt_d  = filt_q;
    fext_d  = fext_q;
    mask_d  = mask_q;
    mode0_d = mode0_q;
    mode1_d = mode1_q;
    roll_d  = roll_q;
    if (wr_en) begin
      for (int i = 0; i < NFILT; i++) begin
        if (cfg_addr == AW'(i)) begin
          filt_d[i] = cfg_wdata[ID_W-1:0];
          fext_d[i] = cfg_wdata[ID_W];
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (cfg_addr == AW'(MASK_BASE + g)) mask_d[g] = cfg_wdata[ID_W-1:0];
      end
      if (cfg_addr == AW'(CTRL_ADDR)) begin
        mode0_d = rx_mode_e'(cfg_wdata[1:0]);
        mode1_d = rx_mode_e'(cfg_wdata[3:2]);
        roll_d  = cfg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= '0;
      fext_q  <= '0;
      mask_q  <= '0;
      mode0_q <= RXM_BOTH;
      mode1_q <= RXM_BOTH;
      roll_q  <= 1'b0;
    end else if (wr_en) begin
      filt_q  <= filt_d;
      fext_q  <= fext_d;
      mask_q  <= mask_d;
      mode0_q <= mode0_d;
      mode1_q <= mode1_d;
      roll_q  <= roll_d;
    end
  end

  assign filt  = filt_q;
  assign fext  = fext_q;
  assign mask  = mask_q;
  assign mode0 = mode0_q;
  assign mode1 = mode1_q;
  assign roll  = roll_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(filt_q) && $stable(fext_q) && $stable(mask_q) &&
                   $stable(mode0_q) && $stable(mode1_q) && $stable(roll_q))); // R10
endmodule

// File: rtl/can_acc_match.sv
module can_acc_match
  import can_acc_pkg::*;
#(
  parameter int ID_W  = CAN_ID_W,
  parameter int SID_W = CAN_SID_W,
  parameter int DB_W  = CAN_DB_W
) (
  input  logic            frm_ide,
  input  logic            frm_rtr,
  input  logic [ID_W-1:0] frm_id,
  input  logic [DB_W-1:0] frm_db0,
  input  logic [DB_W-1:0] frm_db1,
  input  logic [ID_W-1:0] filt,
  input  logic            fext,
  input  logic [ID_W-1:0] mask,
  output logic            hit
);
  localparam int EXT_W  = ID_W - SID_W;
  localparam int DATA_W = 2 * DB_W;
  localparam int GAP_W  = EXT_W - DATA_W;

  logic [ID_W-1:0] cmp_vec;
  logic [ID_W-1:0] care;

  always_comb begin
    if (frm_ide) begin
      cmp_vec = frm_id;
      care    = '1;
    end else begin
      cmp_vec = {frm_id[ID_W-1:EXT_W], {GAP_W{1'b0}}, frm_db0, frm_db1};
      if (frm_rtr) care = {{SID_W{1'b1}}, {EXT_W{1'b0}}};
      else         care = {{SID_W{1'b1}}, {GAP_W{1'b0}}, {DATA_W{1'b1}}};
    end
    hit = (fext == frm_ide) && (((cmp_vec ^ filt) & mask & care) == '0);
  end
endmodule

// File: rtl/can_acc_route.sv
module can_acc_route
  import can_acc_pkg::*;
#(
  parameter int NFILT = CAN_NFILT,
  parameter int NF0   = CAN_NF0,
  parameter int HIT_W = $clog2(NFILT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_ok,
  input  logic             frm_ide,
  input  logic [NFILT-1:0] hits,
  input  rx_mode_e         mode0,
  input  rx_mode_e         mode1,
  input  logic             roll,
  input  logic             rel0,
  input  logic             rel1,
  output logic             load0,
  output logic             load1,
  output logic [HIT_W-1:0] hit_idx,
  output logic             ovf,
  output logic             full0,
  output logic             full1
);
  localparam logic [HIT_W-1:0] NO_FILT = '1;

  logic             load0_q, load0_d, load1_q, load1_d, ovf_q, ovf_d;
  logic             full0_q, full0_d, full1_q, full1_d;
  logic [HIT_W-1:0] hit_q, hit_d, idx0, idx1;
  logic             hit_en;
  logic             any0, any1, perm0, perm1, acc0, acc1;

  function automatic logic mode_permits(rx_mode_e m, logic ide);
    return (m == RXM_BOTH) || (m == RXM_STD && !ide) || (m == RXM_EXT && ide);
  endfunction

  always_comb begin
    any0  = (mode0 == RXM_ANY);
    any1  = (mode1 == RXM_ANY);
    perm0 = mode_permits(mode0, frm_ide);
    perm1 = mode_permits(mode1, frm_ide);
    acc0  = any0 || (perm0 && (|hits[NF0-1:0]));
    acc1  = any1 || (perm1 && (|hits[NFILT-1:NF0]));
    idx0  = NO_FILT;
    if (!any0) begin
      for (int i = NF0 - 1; i >= 0; i--) if (hits[i]) idx0 = HIT_W'(i);
    end
    idx1  = NO_FILT;
    if (!any1) begin
      for (int i = NFILT - 1; i >= NF0; i--) if (hits[i]) idx1 = HIT_W'(i);
    end
  end

  always_comb begin
    load0_d = 1'b0;
    load1_d = 1'b0;
    ovf_d   = 1'b0;
    hit_d   = hit_q;
    full0_d = full0_q && !rel0;
    full1_d = full1_q && !rel1;
    if (frm_ok) begin
      if (acc0) begin
        hit_d = idx0;
        if (!full0_q)              load0_d = 1'b1;
        else if (roll && !full1_q) load1_d = 1'b1;
        else                       ovf_d   = 1'b1;
      end else if (acc1) begin
        hit_d = idx1;
        if (!full1_q) load1_d = 1'b1;
        else          ovf_d   = 1'b1;
      end
    end
    if (load0_d) full0_d = 1'b1;
    if (load1_d) full1_d = 1'b1;
    hit_en = load0_d || load1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load0_q <= 1'b0;
      load1_q <= 1'b0;
      ovf_q   <= 1'b0;
      full0_q <= 1'b0;
      full1_q <= 1'b0;
    end else begin
      load0_q <= load0_d;
      load1_q <= load1_d;
      ovf_q   <= ovf_d;
      full0_q <= full0_d;
      full1_q <= full1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= '0;
    else if (hit_en) hit_q <= hit_d;
  end

  assign load0   = load0_q;
  assign load1   = load1_q;
  assign ovf     = ovf_q;
  assign full0   = full0_q;
  assign full1   = full1_q;
  assign hit_idx = hit_q;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load0_q && load1_q)); // R12
  AST_LOAD0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load0_q |-> !$past(full0_q)); // R7
  AST_LOAD1_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load1_q |-> !$past(full1_q)); // R7
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load0_q |-> full0_q) and (load1_q |-> full1_q)); // R7
  AST_NO_OVERFLOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> !(load0_q || load1_q)); // R8
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> ($past(full0_q) || $past(full1_q))); // R8
endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
  import can_acc_pkg::*;
#(
  parameter int ID_W  = CAN_ID_W,
  parameter int SID_W = CAN_SID_W,
  parameter int DB_W  = CAN_DB_W,
  parameter int NFILT = CAN_NFILT,
  parameter int NF0   = CAN_NF0,
  parameter int AW    = $clog2(NFILT + 3),
  parameter int DW    = ID_W + 1,
  parameter int HIT_W = $clog2(NFILT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             frm_valid,
  input  logic             frm_ide,
  input  logic             frm_rtr,
  input  logic [ID_W-1:0]  frm_id,
  input  logic [DB_W-1:0]  frm_db0,
  input  logic [DB_W-1:0]  frm_db1,
  input  logic             rel0,
  input  logic             rel1,
  output logic             load0,
  output logic             load1,
  output logic [HIT_W-1:0] hit_idx,
  output logic             ovf,
  output logic             full0,
  output logic             full1
);
  logic [NFILT-1:0][ID_W-1:0] filt;
  logic [NFILT-1:0]           fext;
  logic [1:0][ID_W-1:0]       mask;
  rx_mode_e                   mode0, mode1;
  logic                       roll;
  logic [NFILT-1:0]           hits;
  logic                       frm_ok;

  assign frm_ok = frm_valid && !cfg_mode;

  can_acc_cfg #(.ID_W(ID_W), .NFILT(NFILT), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .filt(filt), .fext(fext),
    .mask(mask), .mode0(mode0), .mode1(mode1), .roll(roll)
  );

  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    localparam int GRP = (i < NF0) ? 0 : 1;
    can_acc_match #(.ID_W(ID_W), .SID_W(SID_W), .DB_W(DB_W)) u_match (
      .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_id(frm_id),
      .frm_db0(frm_db0), .frm_db1(frm_db1), .filt(filt[i]),
      .fext(fext[i]), .mask(mask[GRP]), .hit(hits[i])
    );
  end

  can_acc_route #(.NFILT(NFILT), .NF0(NF0), .HIT_W(HIT_W)) u_route (
    .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .frm_ide(frm_ide),
    .hits(hits), .mode0(mode0), .mode1(mode1), .roll(roll),
    .rel0(rel0), .rel1(rel1), .load0(load0), .load1(load1),
    .hit_idx(hit_idx), .ovf(ovf), .full0(full0), .full1(full1)
  );

  AST_NO_RX_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> !(load0 || load1 || ovf)); // R11
endmodule

// File: tb/tb_can_rx_accept.sv
module tb_can_rx_accept;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode, cfg_we;
  logic [3:0]  cfg_addr;
  logic [29:0] cfg_wdata;
  logic        frm_valid, frm_ide, frm_rtr;
  logic [28:0] frm_id;
  logic [7:0]  frm_db0, frm_db1;
  logic        rel0, rel1;
  logic        load0, load1, ovf, full0, full1;
  logic [2:0]  hit_idx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  can_rx_accept dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .frm_valid(frm_valid),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_id(frm_id),
    .frm_db0(frm_db0), .frm_db1(frm_db1), .rel0(rel0), .rel1(rel1),
    .load0(load0), .load1(load1), .hit_idx(hit_idx), .ovf(ovf),
    .full0(full0), .full1(full1)
  );

  function automatic logic [28:0] sid(input int v);
    return 29'(v) << 18;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [29:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // exp_buf: 0, 1, or -1 for no load
  task automatic frame(input logic ide, input logic rtr, input logic [28:0] id,
                       input logic [7:0] b0, input logic [7:0] b1,
                       input int exp_buf, input int exp_hit, input bit exp_ovf,
                       input string req);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
    frm_db0 = b0; frm_db1 = b1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk(load0 == (exp_buf == 0), {req, " load0"}, load0, exp_buf == 0);
    chk(load1 == (exp_buf == 1), {req, " load1"}, load1, exp_buf == 1);
    chk(ovf == exp_ovf, {req, " ovf"}, ovf, exp_ovf);
    if (exp_buf >= 0) chk(hit_idx == 3'(exp_hit), {req, " hit_idx"}, hit_idx, exp_hit);
  endtask

  task automatic release_all();
    @(negedge clk);
    rel0 = 1'b1; rel1 = 1'b1;
    @(negedge clk);
    rel0 = 1'b0; rel1 = 1'b0;
    chk(!full0 && !full1, "R7 release clears flags", {full1, full0}, 0);
  endtask

  task automatic t_reset();
    chk(!load0 && !load1 && !ovf, "R1 reset pulses", {load1, load0, ovf}, 0);
    chk(!full0 && !full1, "R1 reset flags", {full1, full0}, 0);
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, 0, 0, 1'b0, "R1 default std");
    chk(full0, "R7 flag after load", full0, 1);
    release_all();
    frame(1'b1, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, -1, 0, 1'b0, "R1 default ext");
  endtask

  task automatic t_configure();
    @(negedge clk); cfg_mode = 1'b1;
    wr(6, {1'b0, 29'h1FFC0000});
    wr(7, {1'b0, 29'h1FFFFFFF});
    wr(0, {1'b0, sid(12'h123)});
    wr(1, {1'b0, sid(12'h456)});
    wr(2, {1'b1, 29'h1ABCDEF5});
    wr(3, {1'b0, sid(12'h123) | 29'hA55A});
    wr(4, {1'b1, 29'h00000077});
    wr(5, {1'b0, sid(12'h7FF)});
    wr(8, 30'h0);
    @(negedge clk); cfg_mode = 1'b0;
  endtask

  task automatic t_match();
    frame(1'b0, 1'b0, sid(12'h456), 8'h11, 8'h22, 0, 1, 1'b0, "R2 masked std");
    release_all();
    frame(1'b0, 1'b0, sid(12'h123), 8'hA5, 8'h5A, 0, 0, 1'b0, "R3 both groups");
    release_all();
    frame(1'b0, 1'b0, sid(12'h124), 8'hA5, 8'h5A, -1, 0, 1'b0, "R2 mismatch");
    frame(1'b1, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 1, 2, 1'b0, "R3 group1 ext");
    release_all();
    frame(1'b1, 1'b0, sid(12'h123), 8'h00, 8'h00, -1, 0, 1'b0, "R2 ext flag");
  endtask

  task automatic t_modes_data();
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b00010); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b0, 1'b0, sid(12'h123), 8'hA5, 8'h5A, 1, 3, 1'b0, "R6 data bytes");
    release_all();
    frame(1'b0, 1'b0, sid(12'h123), 8'hA5, 8'h5B, -1, 0, 1'b0, "R6 data mismatch");
    frame(1'b0, 1'b1, sid(12'h123), 8'h00, 8'h00, 1, 3, 1'b0, "R6 remote ignores data");
    release_all();
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b00100); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b1, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, -1, 0, 1'b0, "R5 std-only rejects ext");
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b00011); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b1, 1'b0, 29'h00000001, 8'h00, 8'h00, 0, 7, 1'b0, "R4 R5 accept-all buf0");
    release_all();
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b01100); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b1, 1'b0, 29'h00000001, 8'h00, 8'h00, 1, 7, 1'b0, "R5 accept-all buf1");
    release_all();
  endtask

  task automatic t_overflow();
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b00000); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, 0, 1, 1'b0, "R7 load");
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, -1, 0, 1'b1, "R8 buf0 full");
    chk(full0 && !full1, "R8 flags unchanged", {full1, full0}, 1);
    frame(1'b1, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 1, 2, 1'b0, "R7 load buf1");
    frame(1'b1, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, -1, 0, 1'b1, "R8 buf1 full");
    release_all();
  endtask

  task automatic t_rollover();
    @(negedge clk); cfg_mode = 1'b1; wr(8, 30'b10000); @(negedge clk); cfg_mode = 1'b0;
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, 0, 1, 1'b0, "R9 first to buf0");
    frame(1'b0, 1'b0, sid(12'h123), 8'hA5, 8'h5A, 1, 0, 1'b0, "R9 rollover");
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, -1, 0, 1'b1, "R9 both full");
    release_all();
  endtask

  task automatic t_lock();
    wr(1, {1'b0, sid(12'h111)});
    wr(8, 30'b00011);
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, 0, 1, 1'b0, "R10 filter kept");
    release_all();
    frame(1'b0, 1'b0, sid(12'h111), 8'h00, 8'h00, -1, 0, 1'b0, "R10 write ignored");
    frame(1'b1, 1'b0, 29'h00000001, 8'h00, 8'h00, -1, 0, 1'b0, "R10 ctrl ignored");
    @(negedge clk); cfg_mode = 1'b1;
    frame(1'b0, 1'b0, sid(12'h456), 8'h00, 8'h00, -1, 0, 1'b0, "R11 cfg halts rx");
    chk(!full0 && !full1, "R11 flags untouched", {full1, full0}, 0);
    @(negedge clk); cfg_mode = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frm_valid = 1'b0; frm_ide = 1'b0; frm_rtr = 1'b0; frm_id = '0;
    frm_db0 = '0; frm_db1 = '0; rel0 = 1'b0; rel1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_configure();
    t_match();
    t_modes_data();
    t_overflow();
    t_rollover();
    t_lock();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule